// File: doc/BRIEF.md
# Multi-Channel Camera Packet Stream Merger

This block joins several AXI4-Stream inputs into one outgoing AXI4-Stream. Each input carries MIPI CSI-2 packets for one virtual channel. It is used where several received camera streams are bridged into a single transmit stream. Every input delivers whole packets. The first beat of a packet is flagged on `tuser[0]` and the last beat on `tlast`. The block serves one input at a time, and a packet it begins is forwarded to its final beat before another input is looked at. The choice among competing inputs is round-robin.

The block has no storage on its inputs. Inputs that are not being served are held off by keeping their `tready` low. The output is a combinational selection of the input being served, so a beat reaches the output in the same cycle it is offered. When more than one channel is configured, the virtual channel field of every packet header is overwritten with the number of the input that carried the packet. The 6-bit header error code is then regenerated so that the header stays consistent. With a single channel, headers pass through untouched.

Top module: `csi_stream_merge`

## Requirements
- R1: Input channel k occupies `in_tdata[k*DATA_W +: DATA_W]`, `in_tkeep[k*DATA_W/8 +: DATA_W/8]` and bit k of `in_tvalid`, `in_tuser`, `in_tlast` and `in_tready`.
- R2: At most one bit of `in_tready` is high in any cycle. That bit belongs to the channel being served and equals `out_tready`. All other channels see `in_tready` low.
- R3: A packet is forwarded contiguously. Once its first beat has been presented at the output, that channel keeps the output until its `tlast` beat is accepted (`out_tvalid && out_tready && out_tlast`), even while other channels are requesting.
- R4: Round-robin: after a packet from channel g completes, the next packet is taken from the first requesting channel in the order g+1, g+2, ..., wrapping from NUM_CH-1 to 0.
- R5: With NUM_CH > 1, bits [7:6] of the first-beat data (the data identifier byte) are replaced by the input channel number. Bits [5:0] keep their value.
- R6: With NUM_CH > 1, bits [31:30] of the first beat are driven to 0 and bits [29:24] carry the header code over the rewritten bits [23:0]. Code bit i is the XOR of the header bits selected by mask i: 0xF12CB7, 0xF2555B, 0x749A6D, 0xB8E38E, 0xDF03F0, 0xEFFC00 (i = 0..5).
- R7: With NUM_CH = 1, every beat, including the header, passes through unchanged.
- R8: Bits above 31 of a first beat, all bits of later beats, and `tkeep`, `tlast` and `tuser` pass unchanged.
- R9: While `out_tvalid` is high and `out_tready` is low, the output beat is held stable. Every input beat is delivered exactly once.
- R10: A synchronous active-high `rst` leaves the block idle, with channel 0 first in round-robin order.
- R11: A channel is eligible for a new packet only when `tvalid` and `tuser[0]` are both high. A valid beat without the start flag on an idle channel is never accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_tdata | input | NUM_CH*DATA_W | Packed input data, channel 0 in the low slice |
| in_tkeep | input | NUM_CH*DATA_W/8 | Packed input byte enables |
| in_tvalid | input | NUM_CH | Per-channel valid |
| in_tuser | input | NUM_CH | Per-channel start-of-packet flag |
| in_tlast | input | NUM_CH | Per-channel end-of-packet flag |
| in_tready | output | NUM_CH | Per-channel ready |
| out_tdata | output | DATA_W | Merged data with patched header |
| out_tkeep | output | DATA_W/8 | Merged byte enables |
| out_tvalid | output | 1 | Merged valid |
| out_tuser | output | 1 | Merged start-of-packet flag |
| out_tlast | output | 1 | Merged end-of-packet flag |
| out_tready | input | 1 | Downstream ready |

## Verification
The assertions check the per-cycle handshake rules on every cycle: that no more than one `in_tready` is high, that a raised ready is matched by `out_tready`, that ownership does not change before the last beat is accepted, that a stalled output stays stable, that a packet started from idle begins with a start-flagged beat, and that reset leaves the block idle. The header rewrite and its error code, the round-robin order across successive packets, and the complete, duplicate-free delivery of every packet under random gaps and backpressure are sequence properties. Only the bench scenarios show these, by comparing each output beat with the packet queued on the input it came from.

// File: rtl/csi_merge_pkg.sv
`timescale 1ns/1ps
package csi_merge_pkg;

    // Bit position of the virtual channel field inside the identifier byte.
    localparam int VC_LSB = 6;

    // Six-bit header code over a 24-bit packet header.
    function automatic logic [5:0] hdr_ecc(input logic [23:0] h);
        logic [5:0] e;
        e[0] = ^(h & 24'hF12CB7);
        e[1] = ^(h & 24'hF2555B);
        e[2] = ^(h & 24'h749A6D);
        e[3] = ^(h & 24'hB8E38E);
        e[4] = ^(h & 24'hDF03F0);
        e[5] = ^(h & 24'hEFFC00);
        return e;
    endfunction

endpackage

// File: rtl/csi_rr_pick.sv
`timescale 1ns/1ps
module csi_rr_pick #(
    parameter int NUM_CH = 4,
    parameter int IDX_W  = 2
) (
    input  logic [NUM_CH-1:0] req,
    input  logic [IDX_W-1:0]  ptr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);

    // Scan from the far end down so the requester closest to ptr wins.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int k = NUM_CH - 1; k >= 0; k--) begin
            int pos;
            pos = int'(ptr) + k;
            if (pos >= NUM_CH) pos = pos - NUM_CH;
            if (req[pos]) begin
                hit = 1'b1;
                idx = IDX_W'(pos);
            end
        end
    end

    always_comb begin
        if (hit) begin
            p_pick_valid_r4: assert (req[idx]);
        end
    end

endmodule

// File: rtl/csi_hdr_patch.sv
`timescale 1ns/1ps
module csi_hdr_patch #(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 64,
    parameter int IDX_W  = 2
) (
    input  logic [DATA_W-1:0] din,
    input  logic              sop,
    input  logic [IDX_W-1:0]  chan,
    output logic [DATA_W-1:0] dout
);

    generate
        if (NUM_CH > 1) begin : g_rewrite
            logic [23:0] hdr;
            logic [5:0]  code;
            always_comb begin
                hdr  = {din[23:csi_merge_pkg::VC_LSB+2], 2'(chan),
                        din[csi_merge_pkg::VC_LSB-1:0]};
                code = csi_merge_pkg::hdr_ecc(hdr);
                dout = din;
                if (sop) begin
                    dout[31:0] = {2'b00, code, hdr};
                end
            end
        end else begin : g_pass
            always_comb dout = din;
            logic unused_ok;
            assign unused_ok = ^{sop, chan};
        end
    endgenerate

endmodule

// File: rtl/csi_stream_merge.sv
`timescale 1ns/1ps
module csi_stream_merge #(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 64
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [NUM_CH*DATA_W-1:0]        in_tdata,
    input  logic [NUM_CH*(DATA_W/8)-1:0]    in_tkeep,
    input  logic [NUM_CH-1:0]               in_tvalid,
    input  logic [NUM_CH-1:0]               in_tuser,
    input  logic [NUM_CH-1:0]               in_tlast,
    output logic [NUM_CH-1:0]               in_tready,
    output logic [DATA_W-1:0]               out_tdata,
    output logic [DATA_W/8-1:0]             out_tkeep,
    output logic                            out_tvalid,
    output logic                            out_tuser,
    output logic                            out_tlast,
    input  logic                            out_tready
);

    localparam int KEEP_W = DATA_W / 8;
    localparam int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] owner;
        logic [IDX_W-1:0] ptr;
    } arb_t;

    arb_t arb_d, arb_q;

    logic [NUM_CH-1:0] sop_req;
    logic              pick_hit;
    logic [IDX_W-1:0]  pick_idx;
    logic [IDX_W-1:0]  sel;
    logic              live;
    logic [DATA_W-1:0] raw_data;
    logic [KEEP_W-1:0] raw_keep;
    logic              raw_valid, raw_sop, raw_last;
    logic              fin;

    assign sop_req = in_tvalid & in_tuser;

    csi_rr_pick #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_pick (
        .req (sop_req),
        .ptr (arb_q.ptr),
        .hit (pick_hit),
        .idx (pick_idx)
    );

    // Owner while busy, otherwise the arbitration winner of this cycle.
    always_comb begin
        sel  = arb_q.busy ? arb_q.owner : pick_idx;
        live = arb_q.busy || pick_hit;
    end

    always_comb begin
        raw_data  = '0;
        raw_keep  = '0;
        raw_valid = 1'b0;
        raw_sop   = 1'b0;
        raw_last  = 1'b0;
        for (int k = 0; k < NUM_CH; k++) begin
            if (sel == IDX_W'(k)) begin
                raw_data  = in_tdata[k*DATA_W +: DATA_W];
                raw_keep  = in_tkeep[k*KEEP_W +: KEEP_W];
                raw_valid = in_tvalid[k];
                raw_sop   = in_tuser[k];
                raw_last  = in_tlast[k];
            end
        end
    end

    csi_hdr_patch #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_patch (
        .din  (raw_data),
        .sop  (raw_sop),
        .chan (sel),
        .dout (out_tdata)
    );

    assign out_tkeep  = raw_keep;
    assign out_tvalid = live && raw_valid;
    assign out_tuser  = raw_sop;
    assign out_tlast  = raw_last;

    generate
        for (genvar k = 0; k < NUM_CH; k++) begin : g_ready
            assign in_tready[k] = live && (sel == IDX_W'(k)) && out_tready;
        end
    endgenerate

    assign fin = out_tvalid && out_tready && out_tlast;

    always_comb begin
        arb_d = arb_q;
        // Lock the winner as soon as its first beat is presented.
        if (!arb_q.busy && pick_hit) begin
            arb_d.busy  = 1'b1;
            arb_d.owner = pick_idx;
        end
        if (fin) begin
            arb_d.busy = 1'b0;
            arb_d.ptr  = (sel == IDX_W'(NUM_CH - 1)) ? '0 : sel + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) arb_q <= '0;
        else     arb_q <= arb_d;
    end

    // ---------------------------------------------------------------
    p_one_ready_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(in_tready));

    p_ready_follows_r2: assert property (@(posedge clk) disable iff (rst)
        (|in_tready) |-> out_tready);

    p_hold_owner_r3: assert property (@(posedge clk) disable iff (rst)
        (arb_q.busy && !fin) |=> (arb_q.busy && arb_q.owner == $past(arb_q.owner)));

    p_stall_stable_r9: assert property (@(posedge clk) disable iff (rst)
        (out_tvalid && !out_tready) |=>
            (out_tvalid && $stable(out_tdata) && $stable(out_tlast)));

    p_first_is_sop_r11: assert property (@(posedge clk) disable iff (rst)
        (!arb_q.busy && out_tvalid) |-> out_tuser);

    p_reset_idle_r10: assert property (@(posedge clk)
        rst |=> (!arb_q.busy && arb_q.ptr == '0));

endmodule

// File: tb/csi_stream_merge_bench.sv
`timescale 1ns/1ps
module csi_stream_merge_bench;

    localparam int N    = 4;
    localparam int DW   = 64;
    localparam int KW   = DW / 8;
    localparam int MAXB = 128;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              rst;
    logic [N*DW-1:0]   in_tdata;
    logic [N*KW-1:0]   in_tkeep;
    logic [N-1:0]      in_tvalid, in_tuser, in_tlast, in_tready;
    logic [DW-1:0]     out_tdata;
    logic [KW-1:0]     out_tkeep;
    logic              out_tvalid, out_tuser, out_tlast, out_tready;

    csi_stream_merge #(.NUM_CH(N), .DATA_W(DW)) u_csi_stream_merge (
        .clk, .rst, .in_tdata, .in_tkeep, .in_tvalid, .in_tuser, .in_tlast,
        .in_tready, .out_tdata, .out_tkeep, .out_tvalid, .out_tuser,
        .out_tlast, .out_tready
    );

    // Single-channel instance for the passthrough mode.
    logic [31:0] s1_in_data, s1_out_data;
    logic [3:0]  s1_in_keep, s1_out_keep;
    logic        s1_in_valid, s1_in_sop, s1_in_last, s1_in_ready;
    logic        s1_out_valid, s1_out_sop, s1_out_last, s1_out_ready;

    csi_stream_merge #(.NUM_CH(1), .DATA_W(32)) u_csi_stream_merge_one (
        .clk, .rst,
        .in_tdata(s1_in_data), .in_tkeep(s1_in_keep), .in_tvalid(s1_in_valid),
        .in_tuser(s1_in_sop), .in_tlast(s1_in_last), .in_tready(s1_in_ready),
        .out_tdata(s1_out_data), .out_tkeep(s1_out_keep), .out_tvalid(s1_out_valid),
        .out_tuser(s1_out_sop), .out_tlast(s1_out_last), .out_tready(s1_out_ready)
    );

    int checks = 0;
    int fails  = 0;

    logic [DW-1:0] s_data [N][MAXB];
    logic [KW-1:0] s_keep [N][MAXB];
    logic          s_sop  [N][MAXB];
    logic          s_last [N][MAXB];
    int            s_cnt [N];
    int            s_rd  [N];
    int            s_chk [N];
    bit            s_vld [N];
    int            order_log [64];
    int            order_n;
    int            pkt_seq = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Header code built from per-bit column codes.
    function automatic logic [5:0] ref_code(input logic [23:0] h);
        logic [5:0] acc = '0;
        for (int i = 0; i < 24; i++) begin
            logic [5:0] col;
            case (i)
                0: col = 6'h07;  1: col = 6'h0B;  2: col = 6'h0D;  3: col = 6'h0E;
                4: col = 6'h13;  5: col = 6'h15;  6: col = 6'h16;  7: col = 6'h19;
                8: col = 6'h1A;  9: col = 6'h1C; 10: col = 6'h23; 11: col = 6'h25;
               12: col = 6'h26; 13: col = 6'h29; 14: col = 6'h2A; 15: col = 6'h2C;
               16: col = 6'h31; 17: col = 6'h32; 18: col = 6'h34; 19: col = 6'h38;
               20: col = 6'h1F; 21: col = 6'h2F; 22: col = 6'h37; default: col = 6'h3B;
            endcase
            if (h[i]) acc = acc ^ col;
        end
        return acc;
    endfunction

    function automatic logic [DW-1:0] expect_beat(input int c, input logic [DW-1:0] d,
                                                  input bit sop);
        logic [23:0] h;
        if (!sop) return d;
        h = {d[23:8], 2'(c), d[5:0]};
        return {d[DW-1:32], 2'b00, ref_code(h), h};
    endfunction

    task automatic clear_src();
        for (int c = 0; c < N; c++) begin
            s_cnt[c] = 0; s_rd[c] = 0; s_chk[c] = 0; s_vld[c] = 1'b0;
        end
        order_n = 0;
    endtask

    task automatic add_pkt(input int c, input int len);
        for (int b = 0; b < len; b++) begin
            logic [DW-1:0] d;
            int i;
            i = s_cnt[c];
            d = {$urandom, $urandom};
            d[39:32] = {4'hA, 4'(c)};
            d[47:40] = 8'(pkt_seq);
            s_data[c][i] = d;
            s_keep[c][i] = (b == len - 1) ? (8'hFF >> ($urandom % 4)) : 8'hFF;
            s_sop[c][i]  = (b == 0);
            s_last[c][i] = (b == len - 1);
            s_cnt[c]++;
        end
        pkt_seq++;
    endtask

    task automatic drive_ch(input int c);
        if (s_vld[c]) begin
            in_tdata[c*DW +: DW] = s_data[c][s_rd[c]];
            in_tkeep[c*KW +: KW] = s_keep[c][s_rd[c]];
            in_tuser[c]  = s_sop[c][s_rd[c]];
            in_tlast[c]  = s_last[c][s_rd[c]];
            in_tvalid[c] = 1'b1;
        end else begin
            in_tdata[c*DW +: DW] = '0;
            in_tkeep[c*KW +: KW] = '0;
            in_tuser[c]  = 1'b0;
            in_tlast[c]  = 1'b0;
            in_tvalid[c] = 1'b0;
        end
    endtask

    task automatic apply_reset();
        rst = 1'b1;
        in_tdata = '0; in_tkeep = '0; in_tvalid = '0; in_tuser = '0; in_tlast = '0;
        out_tready = 1'b0;
        s1_in_data = '0; s1_in_keep = '0; s1_in_valid = 1'b0;
        s1_in_sop = 1'b0; s1_in_last = 1'b0; s1_out_ready = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    function automatic bit all_done(input logic [N-1:0] mask);
        for (int c = 0; c < N; c++)
            if (mask[c] && s_chk[c] < s_cnt[c]) return 1'b0;
        return 1'b1;
    endfunction

    // Output monitor: compares one accepted beat with the queued source beat.
    bit mon_busy = 1'b0;
    int mon_cur  = 0;

    task automatic watch_beat();
        int c;
        logic [DW-1:0] exp;
        c = int'(out_tdata[35:32]);
        if (c >= N || out_tdata[39:36] != 4'hA) begin
            check(1'b0, "R1", "beat tag names no channel", 64'(out_tdata[39:32]), 64'hA0);
            return;
        end
        if (!mon_busy) check(out_tuser == 1'b1, "R3", "packet opens with start beat",
                             64'(out_tuser), 64'd1);
        else           check(c == mon_cur, "R3", "beat from other channel inside packet",
                             64'(c), 64'(mon_cur));
        if (!mon_busy) mon_cur = c;
        exp = expect_beat(c, s_data[c][s_chk[c]], s_sop[c][s_chk[c]]);
        if (s_sop[c][s_chk[c]]) begin
            check(out_tdata[7:6] == 2'(c), "R5", "virtual channel field",
                  64'(out_tdata[7:6]), 64'(c));
            check(out_tdata == exp, "R6", "header code / first beat", out_tdata, exp);
        end else begin
            check(out_tdata == exp, "R8", "payload beat", out_tdata, exp);
        end
        check(out_tkeep == s_keep[c][s_chk[c]] && out_tlast == s_last[c][s_chk[c]],
              "R8", "keep/last", {out_tkeep, 7'd0, out_tlast},
              {s_keep[c][s_chk[c]], 7'd0, s_last[c][s_chk[c]]});
        s_chk[c]++;
        mon_busy = !out_tlast;
        if (out_tlast && order_n < 64) begin
            order_log[order_n] = c;
            order_n++;
        end
    endtask

    // Traffic engine: drives masked channels, samples at the falling edge.
    task automatic run(input logic [N-1:0] mask, input bit gaps, input int rdy_pct,
                       input int limit);
        int  cyc = 0;
        bit  fired [N];
        bit  stray = 1'b0;
        mon_busy = 1'b0;
        for (int c = 0; c < N; c++) begin
            if (mask[c]) begin
                if (!s_vld[c] && s_rd[c] < s_cnt[c] && (!gaps || $urandom % 3 != 0))
                    s_vld[c] = 1'b1;
                drive_ch(c);
            end
        end
        out_tready = (int'($urandom % 100) < rdy_pct);
        while (!all_done(mask) && cyc < limit) begin
            @(negedge clk);
            for (int c = 0; c < N; c++) begin
                fired[c] = in_tvalid[c] && in_tready[c];
                if (!mask[c] && in_tready[c]) stray = 1'b1;
            end
            if (out_tvalid && out_tready) watch_beat();
            @(posedge clk);
            #1;
            for (int c = 0; c < N; c++) begin
                if (mask[c]) begin
                    if (fired[c]) begin
                        s_rd[c]++;
                        s_vld[c] = 1'b0;
                    end
                    if (!s_vld[c] && s_rd[c] < s_cnt[c] && (!gaps || $urandom % 3 != 0))
                        s_vld[c] = 1'b1;
                    drive_ch(c);
                end
            end
            out_tready = (int'($urandom % 100) < rdy_pct);
            cyc++;
        end
        check(cyc < limit, "R9", "traffic run finished (watchdog)", 64'(cyc), 64'(limit));
        check(!stray, "R11", "ready raised on channel outside the run", 64'(stray), 64'd0);
        out_tready = 1'b0;
    endtask

    // ---------------------------------------------------------------
    task automatic t_reset();
        apply_reset();
        @(negedge clk);
        check(out_tvalid == 1'b0, "R10", "output idle after reset", 64'(out_tvalid), 64'd0);
        check(in_tready == '0, "R2", "no ready after reset", 64'(in_tready), 64'd0);
        @(posedge clk);
        #1;
    endtask

    task automatic t_rr_order();
        apply_reset();
        clear_src();
        for (int p = 0; p < 2; p++)
            for (int c = 0; c < N; c++) add_pkt(c, 2);
        run(4'hF, 1'b0, 100, 400);
        check(order_n == 8, "R4", "packets completed", 64'(order_n), 64'd8);
        for (int i = 0; i < 8; i++)
            check(order_log[i] == (i % N), "R4", "round-robin order (R10 starts at 0)",
                  64'(order_log[i]), 64'(i % N));
    endtask

    task automatic t_stall();
        logic [DW-1:0] first;
        apply_reset();
        clear_src();
        add_pkt(2, 3);
        add_pkt(0, 2);
        first = expect_beat(2, s_data[2][0], 1'b1);
        s_vld[2] = 1'b1;
        drive_ch(2);
        out_tready = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(out_tvalid == 1'b1, "R9", "valid held while stalled", 64'(out_tvalid), 64'd1);
            check(out_tdata == first, "R9", "data held while stalled", out_tdata, first);
            check(in_tready == '0, "R2", "ready low while output stalled",
                  64'(in_tready), 64'd0);
            @(posedge clk);
            #1;
            if (i == 1) begin
                s_vld[0] = 1'b1;
                drive_ch(0);
            end
        end
        run(4'b0101, 1'b0, 100, 200);
        check(order_n == 2 && order_log[0] == 2, "R3", "presented packet keeps the output",
              64'(order_log[0]), 64'd2);
        check(order_log[1] == 0, "R3", "late requester served after", 64'(order_log[1]), 64'd0);
    endtask

    task automatic t_no_sop();
        apply_reset();
        clear_src();
        in_tdata[1*DW +: DW] = {16{4'h5}};
        in_tkeep[1*KW +: KW] = '1;
        in_tuser[1]  = 1'b0;
        in_tlast[1]  = 1'b0;
        in_tvalid[1] = 1'b1;
        add_pkt(3, 2);
        add_pkt(3, 1);
        run(4'b1000, 1'b0, 100, 200);
        check(order_n == 2 && order_log[0] == 3 && order_log[1] == 3, "R11",
              "only start-flagged channel served", 64'(order_n), 64'd2);
        @(negedge clk);
        check(in_tready[1] == 1'b0, "R11", "non-start beat left waiting",
              64'(in_tready[1]), 64'd0);
        @(posedge clk);
        #1;
        in_tvalid[1] = 1'b0;
    endtask

    task automatic t_random();
        apply_reset();
        clear_src();
        for (int p = 0; p < 6; p++)
            for (int c = 0; c < N; c++) add_pkt(c, 1 + int'($urandom % 5));
        run(4'hF, 1'b1, 60, 20000);
        for (int c = 0; c < N; c++)
            check(s_chk[c] == s_cnt[c], "R9", "every beat delivered once",
                  64'(s_chk[c]), 64'(s_cnt[c]));
        check(order_n == 6 * N, "R1", "all packets of all channels seen",
              64'(order_n), 64'(6 * N));
    endtask

    task automatic t_single();
        apply_reset();
        s1_in_data  = 32'h7E_12_34_EB;
        s1_in_keep  = 4'hF;
        s1_in_sop   = 1'b1;
        s1_in_last  = 1'b0;
        s1_in_valid = 1'b1;
        s1_out_ready = 1'b1;
        @(negedge clk);
        check(s1_out_valid && s1_out_data == 32'h7E_12_34_EB, "R7", "header unchanged",
              64'(s1_out_data), 64'h7E1234EB);
        check(s1_in_ready == 1'b1, "R7", "single channel ready", 64'(s1_in_ready), 64'd1);
        @(posedge clk);
        #1;
        s1_in_data = 32'hC0FFEE01;
        s1_in_sop  = 1'b0;
        s1_in_last = 1'b1;
        s1_in_keep = 4'h3;
        @(negedge clk);
        check(s1_out_data == 32'hC0FFEE01 && s1_out_last && s1_out_keep == 4'h3, "R7",
              "payload beat unchanged", 64'(s1_out_data), 64'hC0FFEE01);
        @(posedge clk);
        #1;
        s1_in_valid = 1'b0;
        s1_in_last  = 1'b0;
        s1_out_ready = 1'b0;
    endtask

    initial begin
        #900000;
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_rr_order();
        t_stall();
        t_no_sop();
        t_random();
        t_single();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule